// File: doc/BRIEF.md
# Low-Speed USB Packet Serialiser

This block turns a short outgoing packet into line states on the two USB data wires at low speed, one bit every twelve clocks. When started from idle it takes the bus, holds the idle (J) state for one bit, and then sends the fixed sync byte. It then sends the payload bytes, each least significant bit first, with NRZI line coding and bit stuffing. It closes with an end-of-packet sequence and lets go of the wires.

Payload bytes arrive over a valid/ready stream into a one-byte holding register. `in_ready` rises only while a packet is in flight, the holding register is empty and bytes are still owed. The source may hold `in_valid` low for as long as it likes, with one limit: the next byte must have been accepted before the last bit of the byte on the wire goes out. If it is late, the packet is cut short after the current byte. Short handshake replies (sync plus one PID byte) are requested with `is_handshake`. A new device address, staged by the caller with `new_addr_pending`, is made active only once a data packet has gone out.

Top module: `usb_lowspeed_tx`

## Requirements
- R1: Every bit slot on the wires lasts exactly BIT_CLKS (12) clocks. `dp`, `dm` and `oe` change only at slot boundaries while a packet is in flight.
- R2: The clock edge that accepts `start` sets `oe`. The wires then show J (`dp`=0, `dm`=1) for one full slot before the first sync bit.
- R3: The sync byte 0x80 goes out first, then the payload bytes in arrival order, each LSB first. A 1 keeps the previous line state and a 0 toggles between J and K. K is `dp`=1, `dm`=0.
- R4: After STUFF_RUN (6) consecutive 1 bits on the wire, one extra toggle slot is inserted and the run count restarts from zero. This also happens after the final payload bit.
- R5: After the last bit, both wires are held low (SE0) for two slots and then at J for one slot. After that, `oe`, `dp` and `dm` all drop to 0, and `done` is high for exactly the first idle cycle.
- R6: `byte_cnt` counts the sync byte and is clamped to the range 2..MAX_BYTES. Exactly count-1 bytes are taken through `in_valid`/`in_ready`, and `in_ready` is never high while `busy` is low.
- R7: With `is_handshake` high at start, the packet holds exactly one payload byte, whatever `byte_cnt` says.
- R8: If `new_addr_pending` is high when SE0 begins, and the packet was not a handshake, `dev_addr` takes `new_addr`. A handshake packet, or no pending address, leaves `dev_addr` unchanged.
- R9: A `start` pulse while `busy` is high has no effect on the packet on the wires.
- R10: If no byte is held when the last bit of the current byte is sent, the packet ends after that byte with the normal end-of-packet sequence.
- R11: After reset, `oe`, `dp`, `dm`, `busy`, `done` and `in_ready` are 0 and `dev_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a packet (taken only when idle) |
| byte_cnt | input | CNT_W | Bytes in packet including sync |
| is_handshake | input | 1 | Packet is a sync-plus-PID handshake reply |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte accepted when high with in_valid |
| new_addr | input | ADDR_W | Staged device address |
| new_addr_pending | input | 1 | Staged address awaits commit |
| dp | output | 1 | D+ drive value |
| dm | output | 1 | D- drive value |
| oe | output | 1 | Output enable for both wires |
| busy | output | 1 | Packet in flight |
| done | output | 1 | One-cycle pulse when the bus is released |
| dev_addr | output | ADDR_W | Active device address |

## Verification
The bench uses the default parameters: twelve clocks per bit, a run limit of six ones, and a maximum of twelve bytes with a four-bit count. With these values an oversized count of 15 reaches the upper clamp and a count of 1 reaches the lower one. Payloads of 0xFF force several stuffed slots, including one after the last payload bit. A whole packet of the longest length stays under two thousand clocks, so random packet lengths across the full range, random stream stalls, an underrun and a start pulse in mid-packet all fit in one short run.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_BITS,
    ST_SE0,
    ST_TAIL
  } tx_state_e;

  typedef enum logic [1:0] {
    DRV_OFF,
    DRV_LINE,
    DRV_SE0
  } drv_mode_e;

  localparam logic [7:0] SYNC_PATTERN = 8'h80;
endpackage

// File: rtl/usb_tx_bit_timer.sv
module usb_tx_bit_timer #(
  parameter int BIT_CLKS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int W = $clog2(BIT_CLKS + 1);
  localparam logic [W-1:0] LAST = W'(BIT_CLKS - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || !run)  cnt <= '0;
    else if (cnt == LAST)      cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assign tick = run && !restart && (cnt == LAST);
endmodule

// File: rtl/usb_tx_feed.sv
module usb_tx_feed #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_count,
  input  logic             active,
  input  logic             take,
  input  logic             flush,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             hold_valid,
  output logic [7:0]       hold_data
);
  logic [CNT_W-1:0] owed;

  assign in_ready = active && !hold_valid && (owed != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed       <= '0;
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else if (load) begin
      owed       <= load_count;
      hold_valid <= 1'b0;
    end else if (flush) begin
      owed       <= '0;
      hold_valid <= 1'b0;
    end else if (in_valid && in_ready) begin
      hold_data  <= in_data;
      hold_valid <= 1'b1;
      owed       <= owed - 1'b1;
    end else if (take) begin
      hold_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_tx_nrzi.sv
module usb_tx_nrzi #(
  parameter int STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic step,
  input  logic bit_in,
  output logic line_j,
  output logic stuff_due
);
  localparam int RW = $clog2(STUFF_RUN + 1);

  logic [RW-1:0] ones;

  assign stuff_due = (ones == RW'(STUFF_RUN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_j <= 1'b1;
      ones   <= '0;
    end else if (init) begin
      line_j <= 1'b1;
      ones   <= '0;
    end else if (step) begin
      if (stuff_due) begin
        line_j <= !line_j;
        ones   <= '0;
      end else if (bit_in) begin
        ones   <= ones + 1'b1;
      end else begin
        line_j <= !line_j;
        ones   <= '0;
      end
    end
  end
endmodule

// File: rtl/usb_lowspeed_tx.sv
module usb_lowspeed_tx #(
  parameter int BIT_CLKS     = 12,
  parameter int MAX_BYTES    = 12,
  parameter int MIN_BYTES    = 2,
  parameter int STUFF_RUN    = 6,
  parameter int EOP_SE0_BITS = 2,
  parameter int ADDR_W       = 7,
  parameter int CNT_W        = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic              is_handshake,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] new_addr,
  input  logic              new_addr_pending,
  output logic              dp,
  output logic              dm,
  output logic              oe,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] dev_addr
);
  import usb_tx_pkg::*;

  localparam int SE0_W = $clog2(EOP_SE0_BITS + 1);
  localparam logic [CNT_W-1:0] HS_BYTES = CNT_W'(2);
  localparam logic [CNT_W-1:0] LO_BYTES = CNT_W'(MIN_BYTES);
  localparam logic [CNT_W-1:0] HI_BYTES = CNT_W'(MAX_BYTES);

  tx_state_e        st;
  drv_mode_e        drv;
  logic [7:0]       shreg;
  logic [2:0]       bit_idx;
  logic             fin;
  logic             hs_q;
  logic [SE0_W-1:0] se0_cnt;
  logic [CNT_W-1:0] eff_cnt;

  logic bit_tick, line_j, stuff_due;
  logic hold_valid;
  logic [7:0] hold_data;

  logic go, sending, emit, advance, end_pkt, take;

  always_comb begin
    if (is_handshake)             eff_cnt = HS_BYTES;
    else if (byte_cnt < LO_BYTES) eff_cnt = LO_BYTES;
    else if (byte_cnt > HI_BYTES) eff_cnt = HI_BYTES;
    else                          eff_cnt = byte_cnt;
  end

  assign go      = start && (st == ST_IDLE);
  assign sending = (st == ST_LEAD) || (st == ST_BITS);
  assign emit    = bit_tick && sending && (stuff_due || !fin);
  assign advance = emit && !stuff_due;
  assign take    = advance && (bit_idx == 3'd7) && hold_valid;
  assign end_pkt = bit_tick && (st == ST_BITS) && fin && !stuff_due;

  usb_tx_bit_timer #(.BIT_CLKS(BIT_CLKS)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st != ST_IDLE),
    .restart (go),
    .tick    (bit_tick)
  );

  usb_tx_feed #(.CNT_W(CNT_W)) feed_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (go),
    .load_count (eff_cnt - 1'b1),
    .active     (sending && !fin),
    .take       (take),
    .flush      (end_pkt),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .hold_valid (hold_valid),
    .hold_data  (hold_data)
  );

  usb_tx_nrzi #(.STUFF_RUN(STUFF_RUN)) nrzi_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (go || end_pkt),
    .step      (emit),
    .bit_in    (shreg[0]),
    .line_j    (line_j),
    .stuff_due (stuff_due)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      drv      <= DRV_OFF;
      shreg    <= '0;
      bit_idx  <= '0;
      fin      <= 1'b0;
      hs_q     <= 1'b0;
      se0_cnt  <= '0;
      done     <= 1'b0;
      dev_addr <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (go) begin
          st      <= ST_LEAD;
          drv     <= DRV_LINE;
          shreg   <= SYNC_PATTERN;
          bit_idx <= '0;
          fin     <= 1'b0;
          hs_q    <= is_handshake;
        end
        ST_LEAD, ST_BITS: begin
          if (emit) st <= ST_BITS;
          if (advance) begin
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) begin
              if (hold_valid) shreg <= hold_data;
              else            fin   <= 1'b1;
            end else begin
              shreg <= {1'b0, shreg[7:1]};
            end
          end
          if (end_pkt) begin
            st      <= ST_SE0;
            drv     <= DRV_SE0;
            se0_cnt <= '0;
            if (!hs_q && new_addr_pending) dev_addr <= new_addr;
          end
        end
        ST_SE0: if (bit_tick) begin
          if (se0_cnt == SE0_W'(EOP_SE0_BITS - 1)) begin
            st  <= ST_TAIL;
            drv <= DRV_LINE;
          end else begin
            se0_cnt <= se0_cnt + 1'b1;
          end
        end
        ST_TAIL: if (bit_tick) begin
          st   <= ST_IDLE;
          drv  <= DRV_OFF;
          done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE);
  assign oe   = (drv != DRV_OFF);
  assign dp   = (drv == DRV_LINE) && !line_j;
  assign dm   = (drv == DRV_LINE) && line_j;
endmodule

// File: rtl/usb_lowspeed_tx_chk.sv
module usb_lowspeed_tx_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              dp,
  input logic              dm,
  input logic              oe,
  input logic              busy,
  input logic              done,
  input logic              in_ready,
  input logic              bit_tick,
  input logic              hs_q,
  input logic [ADDR_W-1:0] dev_addr
);
  p_never_both_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp && dm));

  p_released_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!oe && !dp && !dm));

  p_lead_is_j_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> (dm && !dp));

  p_slot_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(bit_tick)) |-> $stable({dp, dm, oe}));

  p_done_on_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_ready_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  p_addr_after_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_addr) |-> ($past(busy) && !hs_q));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !bit_tick) |=> busy);
endmodule

bind usb_lowspeed_tx usb_lowspeed_tx_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .dp       (dp),
  .dm       (dm),
  .oe       (oe),
  .busy     (busy),
  .done     (done),
  .in_ready (in_ready),
  .bit_tick (bit_tick),
  .hs_q     (hs_q),
  .dev_addr (dev_addr)
);

// File: tb/usb_lowspeed_tx_tb_top.sv
`timescale 1ns/1ps
module usb_lowspeed_tx_tb_top;
  localparam int SYM_REL = 0, SYM_J = 1, SYM_K = 2, SYM_SE0 = 3, SYM_BAD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] byte_cnt = '0;
  logic       is_handshake = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic [6:0] new_addr = '0;
  logic       new_addr_pending = 1'b0;
  logic       dp, dm, oe, busy, done;
  logic [6:0] dev_addr;

  int total = 0;
  int bad = 0;
  logic [7:0] pay [12];
  int exp_sym [160];
  int nsym;

  always #4 clk = ~clk;

  usb_lowspeed_tx dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
    .is_handshake(is_handshake), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .new_addr(new_addr), .new_addr_pending(new_addr_pending),
    .dp(dp), .dm(dm), .oe(oe), .busy(busy), .done(done), .dev_addr(dev_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int sym();
    if (!oe) return (dp || dm) ? SYM_BAD : SYM_REL;
    if (dp && dm) return SYM_BAD;
    if (dp) return SYM_K;
    if (dm) return SYM_J;
    return SYM_SE0;
  endfunction

  // Reference line sequence: lead J, NRZI + stuffing of sync and payload, EOP, release
  function automatic void build_expect(input int n);
    int line = SYM_J;
    int ones = 0;
    logic [7:0] b;
    nsym = 0;
    exp_sym[nsym++] = SYM_J;
    for (int i = 0; i <= n; i++) begin
      b = (i == 0) ? 8'h80 : pay[i-1];
      for (int k = 0; k < 8; k++) begin
        if (b[k]) ones++;
        else begin line = (line == SYM_J) ? SYM_K : SYM_J; ones = 0; end
        exp_sym[nsym++] = line;
        if (ones == 6) begin
          line = (line == SYM_J) ? SYM_K : SYM_J;
          ones = 0;
          exp_sym[nsym++] = line;
        end
      end
    end
    exp_sym[nsym++] = SYM_SE0;
    exp_sym[nsym++] = SYM_SE0;
    exp_sym[nsym++] = SYM_J;
    exp_sym[nsym++] = SYM_REL;
  endfunction

  task automatic run_pkt(input int cnt_in, input bit hs, input int n_pay,
                         input bit pend, input logic [6:0] addr,
                         input bit poke, input string tag);
    logic [6:0] old_addr;
    logic [6:0] exp_addr;
    int accepted = 0;
    int first_bad = -1;
    int bad_act = 0;
    int r1_bad = 0;
    int done_seen = 0;
    int busy_seen = 1;
    int ready_after = 0;
    old_addr = dev_addr;
    exp_addr = (!hs && pend) ? addr : old_addr;
    build_expect(n_pay);
    @(negedge clk);
    start = 1'b1; byte_cnt = 4'(cnt_in); is_handshake = hs;
    new_addr = addr; new_addr_pending = pend;
    @(negedge clk);
    start = 1'b0;
    fork
      begin : supplier
        for (int i = 0; i < n_pay; i++) begin
          int waited = 0;
          repeat ($urandom % 20) @(negedge clk);
          in_valid = 1'b1; in_data = pay[i];
          while (!in_ready && waited < 3000) begin @(negedge clk); waited++; end
          if (in_ready) accepted++;
          @(negedge clk);
          in_valid = 1'b0;
        end
      end
      begin : monitor
        int pos = 0;
        for (int k = 0; k < nsym; k++) begin
          int a, b;
          while (pos < 12*k) begin @(negedge clk); pos++; end
          if (k == nsym - 1) begin done_seen = done; busy_seen = busy; end
          while (pos < 12*k + 1) begin @(negedge clk); pos++; end
          a = sym();
          while (pos < 12*k + 11) begin @(negedge clk); pos++; end
          b = sym();
          if (a != b) r1_bad++;
          if (b != exp_sym[k] && first_bad < 0) begin first_bad = k; bad_act = b; end
        end
        ready_after = in_ready;
      end
      begin : poker
        if (poke) begin
          repeat (200) @(negedge clk);
          start = 1'b1; byte_cnt = 4'd2; is_handshake = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
    chk(r1_bad == 0, {tag, " R1 slot held 12 clocks"}, r1_bad, 0);
    chk(exp_sym[0] == SYM_J && (first_bad != 0), {tag, " R2 lead J"}, first_bad, -1);
    chk(first_bad < 0, {tag, " line sequence (slot index)"}, first_bad,
        -1);
    if (first_bad >= 0)
      chk(0, {tag, " symbol at mismatch"}, bad_act, exp_sym[first_bad]);
    chk(done_seen == 1 && busy_seen == 0, {tag, " R5 done pulse on release"}, done_seen, 1);
    chk(accepted == n_pay && ready_after == 0, {tag, " R6 bytes accepted"}, accepted, n_pay);
    chk(dev_addr == exp_addr, {tag, " R8 device address"}, int'(dev_addr), int'(exp_addr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(!oe && !dp && !dm, "R11 lines released", {oe, dp, dm}, 0);
    chk(!busy && !done && !in_ready, "R11 status low", {busy, done, in_ready}, 0);
    chk(dev_addr == 0, "R11 address zero", int'(dev_addr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    pay[0] = 8'hA5; pay[1] = 8'h3C;
    run_pkt(3, 0, 2, 1, 7'h15, 0, "R3 data pkt");
    for (int i = 0; i < 3; i++) pay[i] = 8'hFF;
    run_pkt(4, 0, 3, 0, 7'h40, 0, "R4 stuffing");
    for (int i = 0; i < 2; i++) pay[i] = 8'h00;
    run_pkt(3, 0, 2, 0, 7'h41, 0, "R3 zeros");
    pay[0] = 8'hD2;
    run_pkt(7, 1, 1, 1, 7'h33, 0, "R7 handshake R8 kept");
    for (int i = 0; i < 11; i++) pay[i] = 8'($urandom);
    run_pkt(15, 0, 11, 0, 7'h00, 0, "R6 clamp high");
    pay[0] = 8'h5A;
    run_pkt(1, 0, 1, 0, 7'h00, 0, "R6 clamp low");
    pay[0] = 8'hC3;
    run_pkt(4, 0, 1, 0, 7'h00, 0, "R10 underrun");
    pay[0] = 8'h12; pay[1] = 8'hFE;
    run_pkt(3, 0, 2, 1, 7'h2A, 1, "R9 start while busy");
    for (int t = 0; t < 6; t++) begin
      int c = 2 + ($urandom % 11);
      for (int i = 0; i < 12; i++) pay[i] = 8'($urandom);
      run_pkt(c, 0, c - 1, 1'($urandom), 7'($urandom), 0, "R3 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule